// File: doc/BRIEF.md
# Memory-Mapped Load/Store Unit

This block is the data-memory stage of a 32-bit integer pipeline. Each request carries an effective address, a 3-bit access-size code taken from the instruction, store data, and separate load and store enables. The two most significant address bits select one of three byte-addressed targets: a general data SRAM, a smaller video RAM and a 16-entry control-register window. Within the chosen target the address is reduced modulo the target size, so any address maps to some byte and multi-byte accesses that run past the top byte continue at byte 0.

Stores write one, two or four bytes in little-endian order. Loads return a 32-bit value that is sign- or zero-extended according to the size code. The control-register window holds no storage. A store to it is passed out as a one-cycle strobe with its index and data, and a load from it always returns zero. A write to the video RAM raises a one-cycle pulse so the display side knows the frame has changed.

Requests enter on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the requester must hold all request fields steady until then. A request with its load enable set produces one response beat on a second valid/ready channel. That beat stays valid with fixed data until it is taken. `req_ready` drops while an untaken response is pending, and rises again in the cycle the consumer raises `rsp_ready`. Store-only requests produce no response. The SRAM and video RAM sizes are parameters. The full-size system uses 2^19 and 2^13 bytes, and the defaults are smaller.

Top module: `lsu_mmap`

## Requirements
- R1: Region select: an address with bit 31 set goes to the control-register window; otherwise an address with bit 30 set goes to the video RAM; every other address goes to the data SRAM.
- R2: The byte index is the address modulo the region size: 16 for the window, 2^VRAM_AW for the video RAM and 2^SRAM_AW for the SRAM. Address bits above the index have no effect, and the bytes of a multi-byte access that pass the last byte continue at byte 0.
- R3: Size codes 000, 001 and 010 select byte, halfword and word for both stores and loads. The least significant byte is at the base index and higher bytes are at increasing indices.
- R4: A load with code 000 copies bit 7 into bits 31:8. A load with code 001 copies bit 15 (bit 7 of the higher byte) into bits 31:16.
- R5: A load with code 100 returns the byte with bits 31:8 zero. A load with code 101 returns the halfword with bits 31:16 zero.
- R6: Every load from the control-register window returns zero, whatever its size code.
- R7: A store with a size code of 000, 001 or 010 to the window sets `sreg_wr_stb` for exactly the cycle after acceptance, with `sreg_wr_idx` equal to address bits 3:0 and `sreg_wr_data` equal to the full store data. No SRAM or video RAM byte changes.
- R8: A store with a valid size code to the video RAM sets `frame_dirty` for exactly the cycle after acceptance. Stores to the SRAM or to the window leave it low.
- R9: Store codes other than 000, 001 and 010 write nothing and raise neither strobe. Load codes other than 000, 001, 010, 100 and 101 return zero, and the response is still delivered.
- R10: When one request has both enables set, the response carries the data held before the store, and the store's bytes are in place for the next request.
- R11: A load response appears with `rsp_valid` in the cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds and `req_ready` is low. A store-only request leaves `rsp_valid` low.
- R12: During and right after reset, `rsp_valid`, `sreg_wr_stb` and `frame_dirty` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_ld | input | 1 | Request includes a load |
| req_st | input | 1 | Request includes a store |
| req_addr | input | 32 | Effective byte address |
| req_size | input | 3 | Access-size code from the instruction |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load result present |
| rsp_ready | input | 1 | Consumer takes the load result |
| rsp_data | output | 32 | Extended load result |
| sreg_wr_stb | output | 1 | One-cycle control-register write strobe |
| sreg_wr_idx | output | 4 | Control-register index |
| sreg_wr_data | output | 32 | Control-register write data |
| frame_dirty | output | 1 | One-cycle pulse after a video RAM write |

## Verification
Two functions can act in the same clock edge.

The first is a load and a store in one request to the same bytes. The bench sends such a request, compares the response with the value the shadow model held before the store, and then reads the bytes back to confirm the store took effect.

The second is the draining of a stalled response in the same edge that takes a waiting request. The bench keeps `rsp_ready` low while a second load waits on the request channel, and checks that the first result holds and `req_ready` stays low. It then raises `rsp_ready` and expects the second result in the very next cycle, with no lost or repeated beat.

// File: rtl/lsu_mmap_pkg.sv
package lsu_mmap_pkg;

  // Target selected by the two top address bits.
  typedef enum logic [1:0] {
    RGN_SRAM = 2'd0,
    RGN_VRAM = 2'd1,
    RGN_SREG = 2'd2
  } region_e;

  // Access-size codes (instruction funct3 field).
  localparam logic [2:0] SZ_BYTE  = 3'b000;
  localparam logic [2:0] SZ_HALF  = 3'b001;
  localparam logic [2:0] SZ_WORD  = 3'b010;
  localparam logic [2:0] SZ_BYTEU = 3'b100;
  localparam logic [2:0] SZ_HALFU = 3'b101;

  localparam int SREG_IDX_W = 4;
  localparam int LANES      = 4;

endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_mmap_pkg::*;
(
  input  logic [1:0] addr_top,
  input  logic [2:0] size,
  output region_e    region,
  output logic [3:0] st_lanes,
  output logic       ld_known
);

  always_comb begin
    if (addr_top[1])      region = RGN_SREG;
    else if (addr_top[0]) region = RGN_VRAM;
    else                  region = RGN_SRAM;
  end

  always_comb begin
    unique case (size)
      SZ_BYTE: st_lanes = 4'b0001;
      SZ_HALF: st_lanes = 4'b0011;
      SZ_WORD: st_lanes = 4'b1111;
      default: st_lanes = 4'b0000;
    endcase
  end

  always_comb begin
    unique case (size)
      SZ_BYTE, SZ_HALF, SZ_WORD, SZ_BYTEU, SZ_HALFU: ld_known = 1'b1;
      default:                                       ld_known = 1'b0;
    endcase
  end

  // R3: written lanes always start at the base byte and are contiguous.
  always_comb begin
    a_r3_lane_shape: assert (st_lanes inside {4'b0000, 4'b0001, 4'b0011, 4'b1111})
      else $error("R3 lane mask malformed");
  end

endmodule

// File: rtl/lsu_byte_ram.sv
module lsu_byte_ram
  import lsu_mmap_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [3:0]    lanes,
  input  logic [AW-1:0] idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem      [DEPTH];
  logic [AW-1:0] lane_idx [LANES];

  // Each lane addresses base+k; AW-bit addition wraps past the top byte.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_idx[k]       = idx + AW'(k);
    assign rdata[8*k +: 8]   = mem[lane_idx[k]];
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (we && lanes[k]) mem[lane_idx[k]] <= wdata[8*k +: 8];
    end
  end

endmodule

// File: rtl/lsu_extend.sv
module lsu_extend
  import lsu_mmap_pkg::*;
(
  input  logic [31:0] bytes_in,
  input  logic [2:0]  size,
  input  region_e     region,
  input  logic        ld_known,
  output logic [31:0] result
);

  always_comb begin
    if (region == RGN_SREG || !ld_known) begin
      result = '0;
    end else begin
      unique case (size)
        SZ_BYTE:  result = {{24{bytes_in[7]}},  bytes_in[7:0]};
        SZ_HALF:  result = {{16{bytes_in[15]}}, bytes_in[15:0]};
        SZ_BYTEU: result = {24'd0, bytes_in[7:0]};
        SZ_HALFU: result = {16'd0, bytes_in[15:0]};
        default:  result = bytes_in;
      endcase
    end
  end

  always_comb begin
    if (region != RGN_SREG && size == SZ_BYTE)
      a_r4_byte_sign: assert (result[31:8] == {24{bytes_in[7]}})
        else $error("R4 byte sign fill wrong");
    if (region != RGN_SREG && size == SZ_HALF)
      a_r4_half_sign: assert (result[31:16] == {16{bytes_in[15]}})
        else $error("R4 half sign fill wrong");
    if (size == SZ_BYTEU)
      a_r5_byte_zero: assert (result[31:8] == 24'd0)
        else $error("R5 byte zero fill wrong");
    if (region == RGN_SREG)
      a_r6_window_zero: assert (result == 32'd0)
        else $error("R6 window load not zero");
  end

endmodule

// File: rtl/lsu_mmap.sv
module lsu_mmap
  import lsu_mmap_pkg::*;
#(
  parameter int SRAM_AW = 10,
  parameter int VRAM_AW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_ld,
  input  logic        req_st,
  input  logic [31:0] req_addr,
  input  logic [2:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data,
  output logic        sreg_wr_stb,
  output logic [3:0]  sreg_wr_idx,
  output logic [31:0] sreg_wr_data,
  output logic        frame_dirty
);

  region_e     region;
  logic [3:0]  st_lanes;
  logic        ld_known;
  logic        accept;
  logic        st_go;
  logic [31:0] sram_rd, vram_rd, rd_bytes, ld_val;
  logic        unused_addr;

  assign unused_addr = ^req_addr;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign st_go     = accept && req_st && (st_lanes != 4'b0000);

  lsu_decode u_decode (
    .addr_top (req_addr[31:30]),
    .size     (req_size),
    .region   (region),
    .st_lanes (st_lanes),
    .ld_known (ld_known)
  );

  lsu_byte_ram #(.AW(SRAM_AW)) u_sram (
    .clk   (clk),
    .we    (st_go && region == RGN_SRAM),
    .lanes (st_lanes),
    .idx   (req_addr[SRAM_AW-1:0]),
    .wdata (req_wdata),
    .rdata (sram_rd)
  );

  lsu_byte_ram #(.AW(VRAM_AW)) u_vram (
    .clk   (clk),
    .we    (st_go && region == RGN_VRAM),
    .lanes (st_lanes),
    .idx   (req_addr[VRAM_AW-1:0]),
    .wdata (req_wdata),
    .rdata (vram_rd)
  );

  assign rd_bytes = (region == RGN_VRAM) ? vram_rd : sram_rd;

  lsu_extend u_extend (
    .bytes_in (rd_bytes),
    .size     (req_size),
    .region   (region),
    .ld_known (ld_known),
    .result   (ld_val)
  );

  // Load result is captured from pre-write memory contents at the accepting edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept && req_ld) begin
      rsp_valid <= 1'b1;
      rsp_data  <= ld_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_wr_stb  <= 1'b0;
      sreg_wr_idx  <= '0;
      sreg_wr_data <= '0;
      frame_dirty  <= 1'b0;
    end else begin
      sreg_wr_stb <= st_go && region == RGN_SREG;
      frame_dirty <= st_go && region == RGN_VRAM;
      if (st_go && region == RGN_SREG) begin
        sreg_wr_idx  <= req_addr[SREG_IDX_W-1:0];
        sreg_wr_data <= req_wdata;
      end
    end
  end

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  a_r11_req_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  a_r11_store_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_ld && rsp_ready |=> !rsp_valid);

  a_r8_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(sreg_wr_stb && frame_dirty));

endmodule

// File: tb/test_lsu_mmap.sv
module test_lsu_mmap;

  localparam int SAW = 6;
  localparam int VAW = 5;
  localparam int SN  = 1 << SAW;
  localparam int VN  = 1 << VAW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ld = 1'b0, req_st = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [2:0]  req_size = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, sreg_wr_stb, frame_dirty;
  logic [31:0] rsp_data, sreg_wr_data;
  logic [3:0]  sreg_wr_idx;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  lsu_mmap #(.SRAM_AW(SAW), .VRAM_AW(VAW)) i_lsu_mmap (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ld(req_ld), .req_st(req_st), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .sreg_wr_stb(sreg_wr_stb), .sreg_wr_idx(sreg_wr_idx),
    .sreg_wr_data(sreg_wr_data), .frame_dirty(frame_dirty)
  );

  logic [7:0] sm [SN];
  logic [7:0] vm [VN];

  logic        got_rv, got_stb, got_fd;
  logic [31:0] got_rd, got_sd, exp_ld;
  logic [3:0]  got_si;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int rgn(input logic [31:0] a);
    if (a[31]) return 2;
    if (a[30]) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] model_load(input logic [31:0] a, input logic [2:0] f3);
    logic [31:0] w;
    int r = rgn(a);
    for (int k = 0; k < 4; k++)
      w[8*k +: 8] = (r == 1) ? vm[(a + k) % VN] : sm[(a + k) % SN];
    if (r == 2) return 32'd0;
    case (f3)
      3'b000: return {{24{w[7]}}, w[7:0]};
      3'b001: return {{16{w[15]}}, w[15:0]};
      3'b010: return w;
      3'b100: return {24'd0, w[7:0]};
      3'b101: return {16'd0, w[15:0]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic int nbytes(input logic [2:0] f3);
    case (f3)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      default: return 0;
    endcase
  endfunction

  task automatic model_store(input logic [31:0] a, input logic [2:0] f3, input logic [31:0] d);
    int r = rgn(a);
    for (int k = 0; k < nbytes(f3); k++) begin
      if (r == 0) sm[(a + k) % SN] = d[8*k +: 8];
      if (r == 1) vm[(a + k) % VN] = d[8*k +: 8];
    end
  endtask

  task automatic access(input bit ld, input bit st, input logic [31:0] a,
                        input logic [2:0] f3, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_ld = ld; req_st = st;
    req_addr = a; req_size = f3; req_wdata = wd;
    exp_ld = model_load(a, f3);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_ld = 1'b0; req_st = 1'b0;
    got_rv = rsp_valid; got_rd = rsp_data; got_stb = sreg_wr_stb;
    got_si = sreg_wr_idx; got_sd = sreg_wr_data; got_fd = frame_dirty;
    if (st) model_store(a, f3, wd);
  endtask

  function automatic logic [31:0] salt(input int i);
    return (i * 32'h0013_579B) & 32'h3FFF_FFC0;
  endfunction

  task automatic sweep_loads(input int base_rgn, input int n);
    logic [2:0] codes [5] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101};
    for (int i = 0; i < n; i++) begin
      for (int c = 0; c < 5; c++) begin
        logic [31:0] a;
        a = (base_rgn == 1) ? (32'h4000_0000 | salt(i + c) | i) : (salt(i + c) | i);
        access(1'b1, 1'b0, a, codes[c], 32'h0);
        chk("R11 load response valid", {31'd0, got_rv}, 32'd1);
        if (codes[c] == 3'b000 || codes[c] == 3'b001)
          chk("R1 R2 R3 R4 signed load", got_rd, exp_ld);
        else if (codes[c] == 3'b010)
          chk("R1 R2 R3 word load", got_rd, exp_ld);
        else
          chk("R1 R2 R5 unsigned load", got_rd, exp_ld);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] exp_a, exp_b;
    for (int i = 0; i < SN; i++) sm[i] = 8'h00;
    for (int i = 0; i < VN; i++) vm[i] = 8'h00;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R12 strobe after reset", {31'd0, sreg_wr_stb}, 32'd0);
    chk("R12 frame_dirty after reset", {31'd0, frame_dirty}, 32'd0);
    chk("R12 req_ready after reset", {31'd0, req_ready}, 32'd1);

    // SRAM byte fill through aliased addresses.
    for (int i = 0; i < SN; i++) begin
      access(1'b0, 1'b1, salt(i) | i, 3'b000, 32'hABCD_0000 | ((i * 37 + 5) & 8'hFF));
      chk("R8 no frame_dirty on SRAM store", {31'd0, got_fd}, 32'd0);
      chk("R11 no response for store", {31'd0, got_rv}, 32'd0);
    end
    sweep_loads(0, SN);

    // Halfword and word stores, including wrap past the top byte.
    for (int i = 0; i < SN; i += 5)
      access(1'b0, 1'b1, salt(i + 7) | i, 3'b001, 32'h5A5A_8000 + i * 32'h0101);
    for (int i = SN - 3; i < SN; i++)
      access(1'b0, 1'b1, i, 3'b010, 32'hC001_D00D ^ (i << 8));
    sweep_loads(0, SN);

    // Video RAM: fill, pulse check, sweep, wrapping word store.
    for (int i = 0; i < VN; i++) begin
      access(1'b0, 1'b1, 32'h4000_0000 | salt(i) | i, 3'b000, (i * 53 + 200) & 8'hFF);
      chk("R8 frame_dirty on video store", {31'd0, got_fd}, 32'd1);
      chk("R7 no window strobe on video store", {31'd0, got_stb}, 32'd0);
    end
    @(negedge clk);
    chk("R8 frame_dirty lasts one cycle", {31'd0, frame_dirty}, 32'd0);
    access(1'b0, 1'b1, 32'h7FFF_FFFF, 3'b010, 32'h8765_4321);
    chk("R1 bit30 address is video", {31'd0, got_fd}, 32'd1);
    access(1'b0, 1'b1, 32'h4000_0003, 3'b001, 32'h0000_F00F);
    sweep_loads(1, VN);

    // Control-register window.
    for (int i = 0; i < 16; i++) begin
      logic [31:0] a;
      a = ((i % 2) ? 32'hC000_0000 : 32'h8000_0000) | (salt(i) & 32'h3FFF_FFF0) | i;
      access(1'b0, 1'b1, a, 3'(i % 3), 32'h1000_0001 * (i + 1));
      chk("R7 window strobe", {31'd0, got_stb}, 32'd1);
      chk("R7 window index", {28'd0, got_si}, i);
      chk("R7 window data", got_sd, 32'h1000_0001 * (i + 1));
      chk("R8 no frame_dirty on window store", {31'd0, got_fd}, 32'd0);
    end
    @(negedge clk);
    chk("R7 strobe lasts one cycle", {31'd0, sreg_wr_stb}, 32'd0);
    begin
      logic [2:0] codes [5] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101};
      for (int c = 0; c < 5; c++) begin
        access(1'b1, 1'b0, 32'hFFFF_FFF0 | c, codes[c], 32'h0);
        chk("R6 window load zero", got_rd, 32'd0);
        chk("R6 window load valid", {31'd0, got_rv}, 32'd1);
      end
    end

    // Unsupported size codes.
    for (int c = 3; c < 8; c++) begin
      if (c == 4 || c == 5) continue;
      access(1'b0, 1'b1, 32'h0000_000A, 3'(c), 32'hDEAD_BEEF);
      chk("R9 bad store no strobe", {30'd0, got_stb, got_fd}, 32'd0);
      access(1'b0, 1'b1, 32'h4000_0004, 3'(c), 32'hDEAD_BEEF);
      chk("R9 bad video store no pulse", {31'd0, got_fd}, 32'd0);
      access(1'b0, 1'b1, 32'h8000_0004, 3'(c), 32'hDEAD_BEEF);
      chk("R9 bad window store no strobe", {31'd0, got_stb}, 32'd0);
      access(1'b1, 1'b0, 32'h0000_000A, 3'(c), 32'h0);
      chk("R9 bad load zero", got_rd, 32'd0);
      chk("R9 bad load still answered", {31'd0, got_rv}, 32'd1);
    end
    access(1'b1, 1'b0, 32'h0000_000A, 3'b010, 32'h0);
    chk("R9 SRAM untouched by bad store", got_rd, exp_ld);
    access(1'b1, 1'b0, 32'h4000_0004, 3'b010, 32'h0);
    chk("R9 video untouched by bad store", got_rd, exp_ld);

    // Load and store in one request.
    access(1'b1, 1'b1, 32'h0000_0014, 3'b010, 32'h1357_9BDF);
    chk("R10 combined returns old data", got_rd, exp_ld);
    access(1'b1, 1'b0, 32'h0000_0014, 3'b010, 32'h0);
    chk("R10 store landed", got_rd, 32'h1357_9BDF);

    // Back-pressure.
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_ld = 1'b1; req_st = 1'b0;
    req_addr = 32'h0000_0014; req_size = 3'b010;
    exp_a = model_load(req_addr, 3'b010);
    @(posedge clk);
    @(negedge clk);
    chk("R11 stalled response valid", {31'd0, rsp_valid}, 32'd1);
    chk("R11 stalled response data", rsp_data, exp_a);
    chk("R11 req_ready low while stalled", {31'd0, req_ready}, 32'd0);
    req_addr = 32'h4000_0001; req_size = 3'b101;
    exp_b = model_load(req_addr, 3'b101);
    for (int n = 0; n < 3; n++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R11 data holds under stall", rsp_data, exp_a);
      chk("R11 request held off", {31'd0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_ld = 1'b0;
    chk("R11 next response follows drain", {31'd0, rsp_valid}, 32'd1);
    chk("R11 next response data", rsp_data, exp_b);
    @(posedge clk);
    @(negedge clk);
    chk("R11 response retired", {31'd0, rsp_valid}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule